// File: doc/BRIEF.md
# Single-Wire Link Initiator Sequencer

This block runs one complete exchange, as the initiating side, on a bidirectional single-wire link with a pull-up. Before a run it is given three things: a slot index, the number of bytes the target will return, and the number of bytes the initiator will send. It then works through a fixed order of steps:

- It drives a low request pulse.
- It confirms that the target is present.
- It collects the target's bytes into a receive register file.
- It turns the line around and transmits the bytes held in a transmit register file.
- It closes with a release pulse and leaves a completion code in a status register.

Every byte on the wire has the same frame. A low sync period comes first, then a one-cycle high mark, then eight data bits with the MSB first, then an even parity bit. Each bit lasts `BIT_CYC` clock cycles. The line is tri-stated by dropping `line_oe_o`, and the bench or the pad resolves it with a pull-up.

Two presence schemes are available through parameter `MULTI`:

- **Header mode (1):** a 7-bit header is sent, then the target's release-and-pull-low acknowledge is polled.
- **Bare mode (0):** the line is sampled one bit period after it is released.

The control and status pins are plain levels and pulses. This block has no streaming data path, so there is no valid/ready back-pressure.

Top module: `link_init_ctrl`

## Requirements
- R1: After reset the line is driven high (`line_oe_o`=1, `line_o`=1), `busy_o` is 0 and `status_o` is 0 (none). The line stays driven high whenever `busy_o` is 0.
- R2: A `start_i` pulse with `index_i` < `SLOTS` sets `busy_o` in the next cycle and drives the line low. In header mode the low run lasts `REQ_CYC`+`BIT_CYC` cycles, covering the request and then the header sync. In bare mode it lasts `REQ_CYC` cycles.
- R3: A `start_i` pulse with `index_i` >= `SLOTS` writes status 4 (type error) in the next cycle and causes no line activity.
- R4: In header mode the header follows the mark. It carries 7 bits, MSB first: `index_i` in the upper 4 bits and the count of ones in `index_i` in the lower 3 bits. An even parity bit comes after them. The line is then held low for `BIT_CYC`/2 cycles and released.
- R5: In header mode, once the released line reads high, it is polled every `POLL_CYC` cycles. If it still reads high when `ACK_POLLS`+2 polls have been taken, the status is set to 2 (no response) and the line is driven high.
- R6: In bare mode, if the line is still high `BIT_CYC` cycles after release, the status is set to 2 and the line is driven high.
- R7: Target bytes are received as framed bytes, each one timed from the low-to-high edge of its mark. Byte k is stored at receive address k and can be read on `rxr_data_o`.
- R8: A received byte whose parity bit fails even parity ends the run at once. The status is set to 3 (data error) and the line is driven high.
- R9: After the last received byte, the block waits for the line to go low and then high. It keeps the line released for `BIT_CYC` cycles, then drives it low for `BIT_CYC`/2 cycles.
- R10: Transmit byte k, taken from transmit address k, is sent as a low sync of `BIT_CYC` cycles, a one-cycle mark, 8 data bits MSB first and an even parity bit.
- R11: After the last transmitted byte, the line is driven low for `BIT_CYC` cycles and then high. `busy_o` falls and the status is set to 1 (end).
- R12: The status holds its value until `status_rd_i` is pulsed while the block is idle. It reads 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the block is idle |
| index_i | input | IDX_W | Slot index |
| rx_len_i | input | LW | Number of bytes expected from the target |
| tx_len_i | input | LW | Number of bytes to send to the target |
| txw_en_i | input | 1 | Transmit register file write enable |
| txw_addr_i | input | AW | Transmit register file write address |
| txw_data_i | input | 8 | Transmit register file write data |
| rxr_addr_i | input | AW | Receive register file read address |
| rxr_data_o | output | 8 | Receive register file read data |
| line_i | input | 1 | Resolved line level |
| line_o | output | 1 | Level driven onto the line |
| line_oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | A run is in progress |
| status_o | output | 3 | 0 none, 1 end, 2 no response, 3 data error, 4 type error |
| status_rd_i | input | 1 | Clear-on-read strobe for the status |

## Verification
The header-mode bench instance uses `BIT_CYC`=8, `REQ_CYC`=4, `POLL_CYC`=2, `ACK_POLLS`=5, `SLOTS`=12 and `MAXB`=4. Short bit periods keep each run to a few hundred cycles, so several random runs fit alongside directed runs with empty and full byte counts. Twelve slots leave indices 12 to 15 free to reach the type-error path. A second instance is built with `MULTI`=0 and no target attached, which reaches the bare-mode presence failure. A target model in the bench supplies acknowledge delays, corrupted parity and the turnaround pulse, so it can drive the poll, data-error and turnaround paths.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_END    = 3'd1,
    ST_NORESP = 3'd2,
    ST_DERR   = 3'd3,
    ST_TYPE   = 3'd4
  } lk_status_e;

  typedef enum logic [4:0] {
    S_IDLE, S_REQ, S_SGL, S_HSYNC, S_MARK, S_HBITS, S_HTAIL, S_ARISE,
    S_APOLL, S_RLOW, S_RHIGH, S_RBITS, S_TLOW, S_THIGH, S_TWAIT,
    S_TDRV, S_XSYNC, S_XBITS, S_FIN
  } lk_state_e;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end
  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/link_regfile.sv
module link_regfile #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))    mem[g] <= wdata_i;
    end
  end
  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/link_frame.sv
module link_frame #(
  parameter int BIT_CYC = 8,
  parameter int W       = 8,
  localparam int HALF   = BIT_CYC / 2,
  localparam int CW     = $clog2(BIT_CYC)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic         rx_i,
  input  logic [3:0]   nbits_i,
  input  logic [W-1:0] txd_i,
  input  logic         line_i,
  output logic         bit_o,
  output logic         done_o,
  output logic         perr_o,
  output logic [W-1:0] rxd_o
);
  logic          active, rxm, par;
  logic [CW-1:0] cnt;
  logic [3:0]    idx, nb;
  logic [W-1:0]  sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; rxm <= 1'b0; par <= 1'b0;
      cnt <= '0; idx <= '0; nb <= '0; sh <= '0;
    end else if (go_i) begin
      active <= 1'b1; rxm <= rx_i; nb <= nbits_i; idx <= '0; par <= 1'b0;
      sh  <= rx_i ? '0 : (txd_i << (W - int'(nbits_i)));
      cnt <= rx_i ? CW'(HALF - 1) : CW'(BIT_CYC - 1);
    end else if (active) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else begin
        cnt <= CW'(BIT_CYC - 1);
        if (idx == nb) active <= 1'b0;
        else begin
          idx <= idx + 4'd1;
          if (rxm) begin
            sh  <= {sh[W-2:0], line_i};
            par <= par ^ line_i;
          end else begin
            sh  <= {sh[W-2:0], 1'b0};
            par <= par ^ sh[W-1];
          end
        end
      end
    end
  end

  assign bit_o  = (idx < nb) ? sh[W-1] : par;
  assign done_o = active && (cnt == '0) && (idx == nb);
  assign perr_o = par ^ line_i;
  assign rxd_o  = sh;
endmodule

// File: rtl/link_init_ctrl.sv
module link_init_ctrl
  import link_pkg::*;
#(
  parameter int MULTI     = 1,
  parameter int SLOTS     = 12,
  parameter int IDX_W     = 4,
  parameter int MAXB      = 4,
  parameter int BIT_CYC   = 8,
  parameter int REQ_CYC   = 4,
  parameter int POLL_CYC  = 2,
  parameter int ACK_POLLS = 5,
  localparam int LW   = $clog2(MAXB + 1),
  localparam int AW   = $clog2(MAXB),
  localparam int HALF = BIT_CYC / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [LW-1:0]    rx_len_i,
  input  logic [LW-1:0]    tx_len_i,
  input  logic             txw_en_i,
  input  logic [AW-1:0]    txw_addr_i,
  input  logic [7:0]       txw_data_i,
  input  logic [AW-1:0]    rxr_addr_i,
  output logic [7:0]       rxr_data_o,
  input  logic             line_i,
  output logic             line_o,
  output logic             line_oe_o,
  output logic             busy_o,
  output logic [2:0]       status_o,
  input  logic             status_rd_i
);
  localparam int MAXT = (BIT_CYC > REQ_CYC) ? ((BIT_CYC > POLL_CYC) ? BIT_CYC : POLL_CYC)
                                            : ((REQ_CYC > POLL_CYC) ? REQ_CYC : POLL_CYC);
  localparam int TW = $clog2(MAXT + 1);
  localparam int PW = $clog2(ACK_POLLS + 2);

  lk_state_e        st;
  lk_status_e       status;
  logic [TW-1:0]    tmr;
  logic [PW-1:0]    pcnt;
  logic [LW-1:0]    bidx, rxn, txn;
  logic [IDX_W-1:0] idx_q;
  logic             hdr_f, line_s;
  logic             f_go, f_rx, f_bit, f_done, f_perr;
  logic [3:0]       f_nb;
  logic [7:0]       f_txd, f_rxd, tx_rd;
  logic [2:0]       pop;

  link_sync #(.STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s));

  link_regfile #(.DEPTH(MAXB), .DW(8)) u_txmem (
    .clk(clk), .rst_n(rst_n), .we_i(txw_en_i), .waddr_i(txw_addr_i),
    .wdata_i(txw_data_i), .raddr_i(bidx[AW-1:0]), .rdata_o(tx_rd));

  link_regfile #(.DEPTH(MAXB), .DW(8)) u_rxmem (
    .clk(clk), .rst_n(rst_n), .we_i(st == S_RBITS && f_done && !f_perr),
    .waddr_i(bidx[AW-1:0]), .wdata_i(f_rxd), .raddr_i(rxr_addr_i), .rdata_o(rxr_data_o));

  always_comb begin
    pop = '0;
    for (int i = 0; i < IDX_W; i++) pop = pop + 3'(idx_q[i]);
  end

  assign f_go  = (st == S_MARK) || (st == S_RHIGH && line_s);
  assign f_rx  = (st == S_RHIGH);
  assign f_nb  = (st == S_MARK && hdr_f) ? 4'(IDX_W + 3) : 4'd8;
  assign f_txd = hdr_f ? 8'({idx_q, pop}) : tx_rd;

  link_frame #(.BIT_CYC(BIT_CYC), .W(8)) u_frame (
    .clk(clk), .rst_n(rst_n), .go_i(f_go), .rx_i(f_rx), .nbits_i(f_nb),
    .txd_i(f_txd), .line_i(line_s), .bit_o(f_bit), .done_o(f_done),
    .perr_o(f_perr), .rxd_o(f_rxd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; status <= ST_NONE; tmr <= '0; pcnt <= '0;
      bidx <= '0; rxn <= '0; txn <= '0; idx_q <= '0; hdr_f <= 1'b0;
    end else begin
      if (status_rd_i && st == S_IDLE) status <= ST_NONE;
      unique case (st)
        S_IDLE: if (start_i) begin
          if ({1'b0, index_i} >= (IDX_W + 1)'(SLOTS)) status <= ST_TYPE;
          else begin
            st <= S_REQ; tmr <= TW'(REQ_CYC - 1); idx_q <= index_i;
            rxn <= rx_len_i; txn <= tx_len_i; bidx <= '0;
          end
        end
        S_REQ: if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            st  <= (MULTI != 0) ? S_HSYNC : S_SGL;
            tmr <= TW'(BIT_CYC - 1); hdr_f <= 1'b1;
          end
        S_SGL: if (tmr != '0) tmr <= tmr - 1'b1;
          else if (line_s) begin st <= S_IDLE; status <= ST_NORESP; end
          else begin st <= (rxn == '0) ? S_TLOW : S_RLOW; hdr_f <= 1'b0; end
        S_HSYNC, S_XSYNC: if (tmr != '0) tmr <= tmr - 1'b1; else st <= S_MARK;
        S_MARK:  st <= hdr_f ? S_HBITS : S_XBITS;
        S_HBITS: if (f_done) begin st <= S_HTAIL; tmr <= TW'(HALF - 1); end
        S_HTAIL: if (tmr != '0) tmr <= tmr - 1'b1; else begin st <= S_ARISE; hdr_f <= 1'b0; end
        S_ARISE: if (line_s) begin st <= S_APOLL; tmr <= '0; pcnt <= '0; end
        S_APOLL: if (tmr != '0) tmr <= tmr - 1'b1;
          else if (!line_s) st <= (rxn == '0) ? S_TLOW : S_RLOW;
          else if (pcnt == PW'(ACK_POLLS + 1)) begin st <= S_IDLE; status <= ST_NORESP; end
          else begin pcnt <= pcnt + 1'b1; tmr <= TW'(POLL_CYC - 1); end
        S_RLOW:  if (!line_s) st <= S_RHIGH;
        S_RHIGH: if (line_s) st <= S_RBITS;
        S_RBITS: if (f_done) begin
          if (f_perr) begin st <= S_IDLE; status <= ST_DERR; end
          else if (bidx + 1'b1 == rxn) begin st <= S_TLOW; bidx <= '0; end
          else begin st <= S_RLOW; bidx <= bidx + 1'b1; end
        end
        S_TLOW:  if (!line_s) st <= S_THIGH;
        S_THIGH: if (line_s) begin st <= S_TWAIT; tmr <= TW'(BIT_CYC - 1); end
        S_TWAIT: if (tmr != '0) tmr <= tmr - 1'b1; else begin st <= S_TDRV; tmr <= TW'(HALF - 1); end
        S_TDRV:  if (tmr != '0) tmr <= tmr - 1'b1;
          else begin st <= (txn == '0) ? S_FIN : S_XSYNC; tmr <= TW'(BIT_CYC - 1); end
        S_XBITS: if (f_done) begin
          tmr <= TW'(BIT_CYC - 1);
          if (bidx + 1'b1 == txn) st <= S_FIN;
          else begin st <= S_XSYNC; bidx <= bidx + 1'b1; end
        end
        S_FIN: if (tmr != '0) tmr <= tmr - 1'b1; else begin st <= S_IDLE; status <= ST_END; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      S_IDLE:                                   begin line_oe_o = 1'b1; line_o = 1'b1; end
      S_REQ, S_HSYNC, S_XSYNC, S_HTAIL, S_TDRV,
      S_FIN:                                    begin line_oe_o = 1'b1; line_o = 1'b0; end
      S_MARK:                                   begin line_oe_o = 1'b1; line_o = 1'b1; end
      S_HBITS, S_XBITS:                         begin line_oe_o = 1'b1; line_o = f_bit; end
      default:                                  begin line_oe_o = 1'b0; line_o = 1'b1; end
    endcase
  end

  assign busy_o   = (st != S_IDLE);
  assign status_o = status;
endmodule

// File: rtl/link_init_chk.sv
module link_init_chk #(
  parameter int SLOTS = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [IDX_W-1:0] index_i,
  input logic             status_rd_i,
  input logic             busy_o,
  input logic             line_o,
  input logic             line_oe_o,
  input logic [2:0]       status_o
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (line_oe_o && line_o));

  assert_req_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && ({1'b0, index_i} < (IDX_W + 1)'(SLOTS)))
    |=> (busy_o && line_oe_o && !line_o));

  assert_type_rej_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && ({1'b0, index_i} >= (IDX_W + 1)'(SLOTS)))
    |=> (!busy_o && status_o == 3'd4));

  assert_done_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (status_o != 3'd0));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd_i && !busy_o && !start_i) |=> (status_o == 3'd0));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !status_rd_i && !start_i) |=> $stable(status_o));
endmodule

bind link_init_ctrl link_init_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i),
  .status_rd_i(status_rd_i), .busy_o(busy_o), .line_o(line_o),
  .line_oe_o(line_oe_o), .status_o(status_o));

// File: tb/link_init_ctrl_tb_top.sv
module link_init_ctrl_tb_top;
  localparam int BITC = 8, HALFC = 4, REQC = 4, SLOTS = 12, MAXB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       start = 0, txw_en = 0, status_rd = 0, t_oe = 0, t_out = 1;
  logic [3:0] index = 0;
  logic [2:0] rx_len = 0, tx_len = 0;
  logic [1:0] txw_addr = 0, rxr_addr = 0;
  logic [7:0] txw_data = 0, rxr_data;
  logic       dut_out, dut_oe, busy;
  logic [2:0] status;
  wire        line = dut_oe ? dut_out : (t_oe ? t_out : 1'b1);

  logic       start2 = 0, out2, oe2, busy2;
  logic [2:0] status2;
  logic [7:0] rxr_data2;
  wire        line2 = oe2 ? out2 : 1'b1;

  int errs = 0, checks = 0;

  link_init_ctrl #(.MULTI(1), .SLOTS(SLOTS), .MAXB(MAXB), .BIT_CYC(BITC),
                   .REQ_CYC(REQC), .POLL_CYC(2), .ACK_POLLS(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .index_i(index), .rx_len_i(rx_len),
    .tx_len_i(tx_len), .txw_en_i(txw_en), .txw_addr_i(txw_addr), .txw_data_i(txw_data),
    .rxr_addr_i(rxr_addr), .rxr_data_o(rxr_data), .line_i(line), .line_o(dut_out),
    .line_oe_o(dut_oe), .busy_o(busy), .status_o(status), .status_rd_i(status_rd));

  link_init_ctrl #(.MULTI(0), .SLOTS(SLOTS), .MAXB(MAXB), .BIT_CYC(BITC),
                   .REQ_CYC(REQC), .POLL_CYC(2), .ACK_POLLS(5)) dut_bare (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .index_i(4'd2), .rx_len_i(3'd1),
    .tx_len_i(3'd1), .txw_en_i(1'b0), .txw_addr_i(2'd0), .txw_data_i(8'd0),
    .rxr_addr_i(2'd0), .rxr_data_o(rxr_data2), .line_i(line2), .line_o(out2),
    .line_oe_o(oe2), .busy_o(busy2), .status_o(status2), .status_rd_i(1'b0));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] hdr_of(input logic [3:0] i);
    return {i, 3'($countones(i))};
  endfunction

  task automatic wait_lvl(input logic v);
    while (line !== v) @(negedge clk);
  endtask

  task automatic sample_bits(input int n, output logic [8:0] v);
    v = '0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      v = {v[7:0], line};
      if (i < n - 1) repeat (BITC) @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit bad);
    t_oe = 1; t_out = 0;
    repeat (BITC) @(negedge clk);
    t_out = 1; @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      t_out = b[i]; repeat (BITC) @(negedge clk);
    end
    t_out = (^b) ^ bad; repeat (BITC) @(negedge clk);
    t_out = 0;
  endtask

  task automatic txn(input int idx, input int nrx, input int ntx, input int ackh,
                     input bit noack, input int badk);
    logic [7:0] rxb [MAXB];
    logic [7:0] txb [MAXB];
    logic [8:0] v;
    int cnt;
    for (int k = 0; k < MAXB; k++) begin
      rxb[k] = 8'($urandom);
      txb[k] = 8'($urandom);
    end
    for (int k = 0; k < MAXB; k++) begin
      txw_en = 1; txw_addr = 2'(k); txw_data = txb[k]; @(negedge clk);
    end
    txw_en = 0;
    index = 4'(idx); rx_len = 3'(nrx); tx_len = 3'(ntx);
    start = 1; @(negedge clk); start = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    cnt = 0;
    while (line == 1'b0 && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == REQC + BITC, "R2 request+sync low run", cnt, REQC + BITC);
    sample_bits(8, v);
    chk(v[7:1] == hdr_of(4'(idx)), "R4 header word", v[7:1], hdr_of(4'(idx)));
    chk(v[0] == ^v[7:1], "R4 header parity", v[0], ^v[7:1]);
    while (dut_oe) @(negedge clk);
    if (noack) begin
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(status == 3'd2, "R5 no response status", status, 2);
      chk(dut_oe && dut_out, "R5 line driven high", {dut_oe, dut_out}, 3);
      return;
    end
    t_oe = 1; t_out = 1;
    repeat (ackh) @(negedge clk);
    t_out = 0;
    for (int k = 0; k < nrx; k++) begin
      send_byte(rxb[k], k == badk);
      if (k == badk) begin
        t_oe = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(status == 3'd3, "R8 data error status", status, 3);
        chk(dut_oe && dut_out, "R8 line driven high", {dut_oe, dut_out}, 3);
        return;
      end
    end
    t_out = 0; repeat (BITC) @(negedge clk);
    t_out = 1; repeat (HALFC) @(negedge clk);
    t_out = 0; @(negedge clk);
    t_oe = 0;
    repeat (4) @(negedge clk);
    chk(dut_oe == 1'b0, "R9 released during turnaround wait", dut_oe, 0);
    repeat (4) @(negedge clk);
    chk(dut_oe && !dut_out, "R9 drives low after wait", {dut_oe, dut_out}, 2);
    for (int k = 0; k < ntx; k++) begin
      wait_lvl(1'b0); wait_lvl(1'b1);
      sample_bits(9, v);
      chk(v[8:1] == txb[k], "R10 sent byte", v[8:1], txb[k]);
      chk(v[0] == ^v[8:1], "R10 sent parity", v[0], ^v[8:1]);
    end
    wait_lvl(1'b0); wait_lvl(1'b1);
    @(negedge clk);
    chk(!busy && status == 3'd1, "R11 end status", status, 1);
    for (int k = 0; k < nrx; k++) begin
      rxr_addr = 2'(k); #1;
      chk(rxr_data == rxb[k], "R7 received byte", rxr_data, rxb[k]);
    end
    repeat (3) @(negedge clk);
    chk(status == 3'd1, "R12 status held", status, 1);
    status_rd = 1; @(negedge clk); status_rd = 0;
    chk(status == 3'd0, "R12 status cleared", status, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dut_oe && dut_out, "R1 idle line high", {dut_oe, dut_out}, 3);
    chk(!busy, "R1 idle not busy", busy, 0);
    chk(status == 3'd0, "R1 reset status", status, 0);

    index = 4'd13; start = 1; @(negedge clk); start = 0;
    chk(status == 3'd4, "R3 type error status", status, 4);
    chk(!busy && dut_oe && dut_out, "R3 no line activity", {busy, dut_oe, dut_out}, 3);
    status_rd = 1; @(negedge clk); status_rd = 0;
    chk(status == 3'd0, "R12 clear after type error", status, 0);

    txn(5, 2, 3, 4, 0, -1);
    txn(0, 0, 0, 3, 0, -1);
    txn(11, MAXB, MAXB, 10, 0, -1);
    txn(3, 3, 1, 5, 0, 1);
    txn(7, 1, 1, 4, 1, -1);
    for (int r = 0; r < 6; r++)
      txn(int'($urandom_range(SLOTS - 1)), int'($urandom_range(MAXB)),
          int'($urandom_range(MAXB)), int'($urandom_range(8, 3)), 0, -1);

    start2 = 1; @(negedge clk); start2 = 0;
    cnt = 0;
    while (line2 == 1'b0 && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == REQC, "R2 bare request low run", cnt, REQC);
    while (busy2) @(negedge clk);
    @(negedge clk);
    chk(status2 == 3'd2, "R6 bare mode no response", status2, 2);
    chk(oe2 && out2, "R6 line driven high", {oe2, out2}, 3);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule